// File: doc/BRIEF.md
# Nine-Bit Message Receive Delimiter

This block takes a single asynchronous serial line that carries nine-bit characters and groups them into messages. The ninth bit sets a character's role. A character with the ninth bit set is a mark and opens a message. A character with the ninth bit clear is a space and continues the message. Every accepted character goes into a power-of-two byte ring. A mark is stored behind a two-byte escape (0xFF then 0x00) so that software can still find message starts inside the payload.

A message is closed when the line has been quiet for a programmable number of milliseconds. With the flush-on-mark option set, a message is also closed when the next mark arrives. Each closed message becomes one start/end index pair in a descriptor queue. The host asks for one message at a time and states how many bytes it can take. It gets back a response code and then the message bytes as a contiguous stream.

Top module: `ninebit_msg_rx`

## Requirements
- R1: The line idles high. A frame is a low start bit, eight data bits least significant first, the ninth (mark) bit and a high stop bit. Each bit lasts CLKS_PER_BIT clock cycles.
- R2: An accepted mark character is stored as three ring bytes: 0xFF, then 0x00, then the data byte. An accepted space character is stored as its data byte alone.
- R3: The ring holds at most RING_DEPTH-1 bytes. A character is accepted only when at least 3 slots are free. Otherwise it is discarded whole, nothing of it is stored, and `overrun_pulse` is high for one cycle.
- R4: Every accepted character restarts the idle timer. After cfg_timeout_ms × TICKS_PER_MS cycles with no accepted character, all stored bytes not yet closed become one message. Before that, they cannot be read.
- R5: When `cfg_flush_on_mark` is 1, an arriving mark first closes the open message and then its own bytes are stored. When it is 0, marks close nothing.
- R6: A close request made when no byte has been stored since the previous close creates no message.
- R7: The descriptor queue has RING_DEPTH/4 entries and holds up to RING_DEPTH/4-1 messages. A close that finds the queue full extends the newest queued message to cover the new bytes, and raises `desc_ovf_pulse` for one cycle.
- R8: A `rd_req` seen while no message is streaming is answered one cycle later with `rsp_valid`. `rsp_code` then reads 0 when no closed message exists (`rsp_len` 0). It reads 1 when the message is longer than `rd_room` (`rsp_len` gives the length, and the message stays queued). It reads 2 when the message is delivered.
- R9: On code 2, the message bytes appear on `out_data` with `out_valid` in consecutive cycles, starting in the `rsp_valid` cycle. `out_last` marks the final byte. The length is (end − start + 1) modulo RING_DEPTH, and a message that crosses the ring end is delivered in order.
- R10: `msg_avail` is high whenever the ring holds unread bytes, whether or not they are closed into a message.
- R11: A `rd_req` raised while a message is streaming is ignored: it gets no response and the stream is unchanged.
- R12: After reset the ring and queue are empty: `msg_avail`, `out_valid`, `rsp_valid` and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| serial_in | input | 1 | Nine-bit serial receive line |
| cfg_timeout_ms | input | MS_W | Idle timeout in milliseconds |
| cfg_flush_on_mark | input | 1 | Close the open message when a mark arrives |
| rd_req | input | 1 | Request one message |
| rd_room | input | AW+1 | Bytes the requester can take |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 2 | 0 empty, 1 too small, 2 delivered |
| rsp_len | output | AW+1 | Message length |
| out_valid | output | 1 | Stream byte valid |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of the message |
| msg_avail | output | 1 | Unread data present in the ring |
| overrun_pulse | output | 1 | A character was discarded for lack of space |
| desc_ovf_pulse | output | 1 | A close was merged into the previous message |

## Verification
Ring writes from the receiver and ring reads for the host stream can happen in the same cycle. Closing a message and retiring one can overlap as well. The bench provokes this by starting a long message pop a fixed number of bit periods after a new mark frame starts, so that the three escape writes land while the stream is still running. The outcome is judged by checking both that the streamed message is byte-exact and that the newly received message reads back whole afterwards.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
    typedef enum logic [1:0] {
        RSP_EMPTY = 2'd0,
        RSP_SHORT = 2'd1,
        RSP_OK    = 2'd2
    } rsp_code_e;

    typedef enum logic [1:0] {
        ESC_IDLE = 2'd0,
        ESC_ZERO = 2'd1,
        ESC_DATA = 2'd2
    } esc_e;

    typedef enum logic [1:0] {
        DS_IDLE  = 2'd0,
        DS_START = 2'd1,
        DS_BITS  = 2'd2,
        DS_STOP  = 2'd3
    } ds_e;
endpackage

// File: rtl/nbr_mem.sv
module nbr_mem #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 32,
    parameter int NRD   = 1,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [AW-1:0]             waddr,
    input  logic [WIDTH-1:0]          wdata,
    input  logic [NRD-1:0][AW-1:0]    raddr,
    output logic [NRD-1:0][WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    // one asynchronous read port per requested reader
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = store[raddr[g]];
    end
endmodule

// File: rtl/nbr_deser.sv
module nbr_deser
    import nbr_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       serial_in,
    output logic       chr_valid,
    output logic [7:0] chr_data,
    output logic       chr_mark
);
    localparam int CW   = $clog2(CLKS_PER_BIT + 1);
    localparam int HALF = CLKS_PER_BIT / 2;

    typedef struct packed {
        ds_e         st;
        logic [CW-1:0] cnt;
        logic [3:0]  nbit;
        logic [8:0]  sh;
        logic        vld;
        logic        s1;
        logic        s2;
    } ds_t;

    ds_t q, d;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        d.s1  = serial_in;
        d.s2  = q.s1;
        case (q.st)
            DS_IDLE: begin
                if (!q.s2) begin
                    d.st  = DS_START;
                    d.cnt = '0;
                end
            end
            DS_START: begin
                if (q.cnt == CW'(HALF - 1)) begin
                    d.cnt  = '0;
                    d.nbit = '0;
                    d.st   = q.s2 ? DS_IDLE : DS_BITS;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            DS_BITS: begin
                if (q.cnt == CW'(CLKS_PER_BIT - 1)) begin
                    d.cnt  = '0;
                    d.sh   = {q.s2, q.sh[8:1]};
                    d.nbit = q.nbit + 1'b1;
                    if (q.nbit == 4'd8) d.st = DS_STOP;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: begin
                if (q.cnt == CW'(CLKS_PER_BIT - 1)) begin
                    d.vld = q.s2;
                    d.st  = DS_IDLE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: DS_IDLE, s1: 1'b1, s2: 1'b1, default: '0};
        else        q <= d;
    end

    assign chr_valid = q.vld;
    assign chr_data  = q.sh[7:0];
    assign chr_mark  = q.sh[8];
endmodule

// File: rtl/nbr_idle_timer.sv
module nbr_idle_timer #(
    parameter int TICKS_PER_MS = 200000,
    parameter int MS_W         = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic [MS_W-1:0] limit_ms,
    output logic            expire
);
    localparam int PW = $clog2(TICKS_PER_MS + 1);

    typedef struct packed {
        logic            armed;
        logic [PW-1:0]   pre;
        logic [MS_W-1:0] ms;
    } tm_t;

    tm_t q, d;
    logic [MS_W-1:0] lim_eff;
    logic            tick;
    logic            reach;

    assign lim_eff = (limit_ms == '0) ? MS_W'(1) : limit_ms;
    assign tick    = q.armed && (q.pre == PW'(TICKS_PER_MS - 1));
    assign reach   = ({1'b0, q.ms} + 1'b1) >= {1'b0, lim_eff};
    assign expire  = tick && reach && !restart;

    always_comb begin
        d = q;
        if (restart) begin
            d.armed = 1'b1;
            d.pre   = '0;
            d.ms    = '0;
        end else if (tick) begin
            d.pre = '0;
            if (reach) d.armed = 1'b0;
            else       d.ms    = q.ms + 1'b1;
        end else if (q.armed) begin
            d.pre = q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/ninebit_msg_rx.sv
module ninebit_msg_rx
    import nbr_pkg::*;
#(
    parameter int RING_DEPTH   = 32,
    parameter int CLKS_PER_BIT = 16,
    parameter int TICKS_PER_MS = 200000,
    parameter int MS_W         = 8,
    localparam int AW          = $clog2(RING_DEPTH),
    localparam int LEN_W       = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             serial_in,
    input  logic [MS_W-1:0]  cfg_timeout_ms,
    input  logic             cfg_flush_on_mark,
    input  logic             rd_req,
    input  logic [LEN_W-1:0] rd_room,
    output logic             rsp_valid,
    output logic [1:0]       rsp_code,
    output logic [LEN_W-1:0] rsp_len,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last,
    output logic             msg_avail,
    output logic             overrun_pulse,
    output logic             desc_ovf_pulse
);
    localparam int DESC_DEPTH = RING_DEPTH / 4;
    localparam int DW         = $clog2(DESC_DEPTH);

    typedef struct packed {
        logic [AW-1:0]    head;
        logic [AW-1:0]    tail;
        logic [AW-1:0]    cur_start;
        logic [AW-1:0]    rptr;
        logic [DW-1:0]    add;
        logic [DW-1:0]    take;
        esc_e             esc;
        logic [7:0]       pend;
        logic             busy;
        logic [LEN_W-1:0] left;
        logic             rsp_valid;
        logic [1:0]       rsp_code;
        logic [LEN_W-1:0] rsp_len;
        logic             ovr;
        logic             ovf;
    } ctl_t;

    ctl_t q, d;

    logic       chr_valid, chr_mark;
    logic [7:0] chr_data;
    logic       tmr_restart, tmr_expire;

    logic          ring_we;
    logic [AW-1:0] ring_wa;
    logic [7:0]    ring_wd;
    logic [0:0][AW-1:0] ring_ra;
    logic [0:0][7:0]    ring_rd;

    logic          dsc_we;
    logic [DW-1:0] dsc_wa;
    logic [AW-1:0] dsc_ws, dsc_wend;
    logic [1:0][DW-1:0] dsc_s_ra;
    logic [1:0][AW-1:0] dsc_s_rd;
    logic [0:0][DW-1:0] dsc_e_ra;
    logic [0:0][AW-1:0] dsc_e_rd;

    logic [AW:0]   used_w, free_w;
    logic [DW-1:0] add_nxt, add_prev;
    logic [AW-1:0] msg_len;
    logic          close;

    nbr_deser #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_deser (
        .clk(clk), .rst_n(rst_n), .serial_in(serial_in),
        .chr_valid(chr_valid), .chr_data(chr_data), .chr_mark(chr_mark)
    );

    nbr_idle_timer #(.TICKS_PER_MS(TICKS_PER_MS), .MS_W(MS_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(tmr_restart),
        .limit_ms(cfg_timeout_ms), .expire(tmr_expire)
    );

    nbr_mem #(.WIDTH(8), .DEPTH(RING_DEPTH), .NRD(1)) u_ring (
        .clk(clk), .we(ring_we), .waddr(ring_wa), .wdata(ring_wd),
        .raddr(ring_ra), .rdata(ring_rd)
    );

    nbr_mem #(.WIDTH(AW), .DEPTH(DESC_DEPTH), .NRD(2)) u_dsc_start (
        .clk(clk), .we(dsc_we), .waddr(dsc_wa), .wdata(dsc_ws),
        .raddr(dsc_s_ra), .rdata(dsc_s_rd)
    );

    nbr_mem #(.WIDTH(AW), .DEPTH(DESC_DEPTH), .NRD(1)) u_dsc_end (
        .clk(clk), .we(dsc_we), .waddr(dsc_wa), .wdata(dsc_wend),
        .raddr(dsc_e_ra), .rdata(dsc_e_rd)
    );

    assign used_w      = {1'b0, q.head - q.tail};
    assign free_w      = (AW + 1)'(RING_DEPTH - 1) - used_w;
    assign add_nxt     = q.add + 1'b1;
    assign add_prev    = q.add - 1'b1;
    assign ring_ra[0]  = q.rptr;
    assign dsc_s_ra[0] = q.take;
    assign dsc_s_ra[1] = add_prev;
    assign dsc_e_ra[0] = q.take;
    assign msg_len     = dsc_e_rd[0] - dsc_s_rd[0] + 1'b1;

    always_comb begin
        d           = q;
        d.rsp_valid = 1'b0;
        d.ovr       = 1'b0;
        d.ovf       = 1'b0;
        ring_we     = 1'b0;
        ring_wa     = q.head;
        ring_wd     = '0;
        dsc_we      = 1'b0;
        dsc_wa      = q.add;
        dsc_ws      = q.cur_start;
        dsc_wend    = q.head - 1'b1;
        tmr_restart = 1'b0;
        close       = tmr_expire;

        // receive side: one ring write per cycle, mark escape spread over three
        case (q.esc)
            ESC_ZERO: begin
                ring_we = 1'b1;
                ring_wd = 8'h00;
                d.head  = q.head + 1'b1;
                d.esc   = ESC_DATA;
            end
            ESC_DATA: begin
                ring_we = 1'b1;
                ring_wd = q.pend;
                d.head  = q.head + 1'b1;
                d.esc   = ESC_IDLE;
            end
            default: begin
                if (chr_valid) begin
                    if (free_w >= (AW + 1)'(3)) begin
                        tmr_restart = 1'b1;
                        ring_we     = 1'b1;
                        d.head      = q.head + 1'b1;
                        if (chr_mark) begin
                            ring_wd = 8'hFF;
                            d.pend  = chr_data;
                            d.esc   = ESC_ZERO;
                            if (cfg_flush_on_mark) close = 1'b1;
                        end else begin
                            ring_wd = chr_data;
                        end
                    end else begin
                        d.ovr = 1'b1;
                    end
                end
            end
        endcase

        // message close: push a descriptor, or merge when the queue is full
        if (close && (q.head != q.cur_start)) begin
            d.cur_start = q.head;
            dsc_we      = 1'b1;
            if (add_nxt != q.take) begin
                d.add = add_nxt;
            end else begin
                dsc_wa = add_prev;
                dsc_ws = dsc_s_rd[1];
                d.ovf  = 1'b1;
            end
        end

        // host side: response, then stream
        if (q.busy) begin
            d.rptr = q.rptr + 1'b1;
            d.left = q.left - 1'b1;
            if (q.left == LEN_W'(1)) begin
                d.busy = 1'b0;
                d.tail = q.rptr + 1'b1;
                d.take = q.take + 1'b1;
            end
        end else if (rd_req) begin
            d.rsp_valid = 1'b1;
            if (q.add == q.take) begin
                d.rsp_code = RSP_EMPTY;
                d.rsp_len  = '0;
            end else begin
                d.rsp_len = {1'b0, msg_len};
                if ({1'b0, msg_len} > rd_room) begin
                    d.rsp_code = RSP_SHORT;
                end else begin
                    d.rsp_code = RSP_OK;
                    d.busy     = 1'b1;
                    d.rptr     = dsc_s_rd[0];
                    d.left     = {1'b0, msg_len};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rsp_valid      = q.rsp_valid;
    assign rsp_code       = q.rsp_code;
    assign rsp_len        = q.rsp_len;
    assign out_valid      = q.busy;
    assign out_data       = ring_rd[0];
    assign out_last       = q.busy && (q.left == LEN_W'(1));
    assign msg_avail      = (q.head != q.tail);
    assign overrun_pulse  = q.ovr;
    assign desc_ovf_pulse = q.ovf;
endmodule

// File: rtl/nbr_rx_checker.sv
module nbr_rx_checker #(
    parameter int LEN_W = 6,
    parameter int AW    = 5,
    parameter int DW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LEN_W-1:0] rd_room,
    input logic             rsp_valid,
    input logic [1:0]       rsp_code,
    input logic [LEN_W-1:0] rsp_len,
    input logic             out_valid,
    input logic             out_last,
    input logic             msg_avail,
    input logic             overrun_pulse,
    input logic             desc_ovf_pulse,
    input logic [AW-1:0]    head,
    input logic [DW-1:0]    add
);
    a_r8_fits_room: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'd2) |-> (rsp_len <= $past(rd_room)));

    a_r8_short_exceeds: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'd1) |-> (rsp_len > $past(rd_room)));

    a_r9_stream_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'd2) |-> out_valid);

    a_r9_stream_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> out_valid);

    a_r11_no_rsp_midstream: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> !rsp_valid);

    a_r3_drop_keeps_head: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_pulse |-> $stable(head));

    a_r7_merge_keeps_queue: assert property (@(posedge clk) disable iff (!rst_n)
        desc_ovf_pulse |-> $stable(add));

    a_r10_avail_on_delivery: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'd2) |-> msg_avail);

    a_r6_no_empty_message: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code != 2'd0) |-> (rsp_len != '0));
endmodule

bind ninebit_msg_rx nbr_rx_checker #(.LEN_W(LEN_W), .AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_room(rd_room), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .rsp_len(rsp_len), .out_valid(out_valid),
    .out_last(out_last), .msg_avail(msg_avail), .overrun_pulse(overrun_pulse),
    .desc_ovf_pulse(desc_ovf_pulse), .head(q.head), .add(q.add)
);

// File: tb/ninebit_msg_rx_test.sv
module ninebit_msg_rx_test;
    localparam int DEPTH = 16;
    localparam int CPB   = 4;
    localparam int TPM   = 8;
    localparam int MSW   = 8;
    localparam int LW    = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ser = 1'b1;
    logic [MSW-1:0] tmo = 8'd8;
    logic          flush = 1'b0;
    logic          rd_req = 1'b0;
    logic [LW-1:0] rd_room = '0;
    logic          rsp_valid, out_valid, out_last, msg_avail, overrun_pulse, desc_ovf_pulse;
    logic [1:0]    rsp_code;
    logic [LW-1:0] rsp_len;
    logic [7:0]    out_data;

    always #2.5 clk = ~clk;

    ninebit_msg_rx #(.RING_DEPTH(DEPTH), .CLKS_PER_BIT(CPB), .TICKS_PER_MS(TPM), .MS_W(MSW)) uut (
        .clk(clk), .rst_n(rst_n), .serial_in(ser), .cfg_timeout_ms(tmo),
        .cfg_flush_on_mark(flush), .rd_req(rd_req), .rd_room(rd_room),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_len(rsp_len),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .msg_avail(msg_avail), .overrun_pulse(overrun_pulse), .desc_ovf_pulse(desc_ovf_pulse)
    );

    int n_checks = 0;
    int n_err    = 0;
    int ovr_cnt  = 0;
    int ovf_cnt  = 0;
    logic [7:0] got [32];
    int got_n, got_code, got_len, last_pos;
    logic [7:0] exp_b [32];
    int exp_n;

    always @(negedge clk) begin
        if (rst_n && overrun_pulse)  ovr_cnt++;
        if (rst_n && desc_ovf_pulse) ovf_cnt++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    // R1 frame: start 0, 8 data LSB first, ninth bit, stop 1 (held 3 bit times)
    task automatic send_frame(input logic [7:0] b, input logic mk);
        ser = 1'b0;
        repeat (CPB) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            ser = b[i];
            repeat (CPB) @(negedge clk);
        end
        ser = mk;
        repeat (CPB) @(negedge clk);
        ser = 1'b1;
        repeat (3 * CPB) @(negedge clk);
    endtask

    task automatic wait_idle();
        repeat (100) @(negedge clk);
    endtask

    task automatic exp_clear();
        exp_n = 0;
    endtask

    task automatic exp_push(input logic [7:0] b);
        exp_b[exp_n] = b;
        exp_n++;
    endtask

    task automatic exp_mark(input logic [7:0] b);
        exp_push(8'hFF); exp_push(8'h00); exp_push(b);
    endtask

    task automatic do_read(input int room);
        got_n    = 0;
        last_pos = -1;
        rd_req   = 1'b1;
        rd_room  = LW'(room);
        @(negedge clk);
        rd_req   = 1'b0;
        got_code = rsp_valid ? int'(rsp_code) : -1;
        got_len  = int'(rsp_len);
        while (out_valid && got_n < 32) begin
            got[got_n] = out_data;
            if (out_last) last_pos = got_n;
            got_n++;
            @(negedge clk);
        end
    endtask

    task automatic expect_msg(input string tag, input int room);
        do_read(room);
        chk({tag, " code"}, got_code, 2);
        chk({tag, " len"}, got_len, exp_n);
        chk({tag, " streamed"}, got_n, exp_n);
        chk({tag, " last"}, last_pos, exp_n - 1);
        for (int i = 0; i < exp_n; i++) chk({tag, " byte"}, int'(got[i]), int'(exp_b[i]));
    endtask

    task automatic expect_empty(input string tag);
        do_read(DEPTH);
        chk({tag, " empty code"}, got_code, 0);
        chk({tag, " empty len"}, got_len, 0);
        chk({tag, " empty stream"}, got_n, 0);
    endtask

    task automatic t_reset();
        chk("R12 msg_avail", int'(msg_avail), 0);
        chk("R12 out_valid", int'(out_valid), 0);
        chk("R12 rsp_valid", int'(rsp_valid), 0);
        chk("R12 pulses", int'(overrun_pulse) + int'(desc_ovf_pulse), 0);
        expect_empty("R8 reset");
    endtask

    task automatic t_basic();
        send_frame(8'h41, 1'b1);
        send_frame(8'h10, 1'b0);
        send_frame(8'hC3, 1'b0);
        chk("R10 open data avail", int'(msg_avail), 1);
        expect_empty("R4 before timeout");
        wait_idle();
        exp_clear(); exp_mark(8'h41); exp_push(8'h10); exp_push(8'hC3);
        expect_msg("R2 R1 R4 R9 basic", DEPTH);
        chk("R10 drained", int'(msg_avail), 0);
    endtask

    task automatic t_short();
        send_frame(8'h55, 1'b1);
        send_frame(8'h66, 1'b0);
        wait_idle();
        do_read(3);
        chk("R8 short code", got_code, 1);
        chk("R8 short len", got_len, 4);
        chk("R8 short no stream", got_n, 0);
        chk("R8 short kept", int'(msg_avail), 1);
        exp_clear(); exp_mark(8'h55); exp_push(8'h66);
        expect_msg("R8 exact room", 4);
    endtask

    task automatic t_ignore();
        send_frame(8'h77, 1'b1);
        send_frame(8'h01, 1'b0);
        send_frame(8'h02, 1'b0);
        send_frame(8'h03, 1'b0);
        wait_idle();
        exp_clear(); exp_mark(8'h77); exp_push(8'h01); exp_push(8'h02); exp_push(8'h03);
        rd_req = 1'b1; rd_room = LW'(DEPTH);
        @(negedge clk);
        rd_req = 1'b0;
        chk("R11 first code", int'(rsp_code), 2);
        for (int i = 0; i < 6; i++) begin
            if (i == 2) chk("R11 second req ignored", int'(rsp_valid), 0);
            chk("R11 stream valid", int'(out_valid), 1);
            chk("R11 stream byte", int'(out_data), int'(exp_b[i]));
            rd_req = (i == 1);
            @(negedge clk);
        end
        rd_req = 1'b0;
        chk("R11 stream ended", int'(out_valid), 0);
        chk("R11 no late rsp", int'(rsp_valid), 0);
    endtask

    task automatic t_flush();
        flush = 1'b1;
        send_frame(8'h41, 1'b1);
        send_frame(8'h81, 1'b0);
        send_frame(8'h42, 1'b1);
        send_frame(8'h82, 1'b0);
        wait_idle();
        exp_clear(); exp_mark(8'h41); exp_push(8'h81);
        expect_msg("R5 flush first", DEPTH);
        exp_clear(); exp_mark(8'h42); exp_push(8'h82);
        expect_msg("R5 flush second", DEPTH);
        expect_empty("R6 no empty message");
        flush = 1'b0;
        send_frame(8'h41, 1'b1);
        send_frame(8'h81, 1'b0);
        send_frame(8'h42, 1'b1);
        send_frame(8'h82, 1'b0);
        wait_idle();
        exp_clear(); exp_mark(8'h41); exp_push(8'h81); exp_mark(8'h42); exp_push(8'h82);
        expect_msg("R5 no flush single", DEPTH);
        repeat (200) @(negedge clk);
        expect_empty("R6 idle close no effect");
    endtask

    task automatic t_full();
        int base;
        base = ovf_cnt;
        for (int i = 1; i <= 4; i++) begin
            send_frame(8'(i * 17), 1'b0);
            wait_idle();
        end
        chk("R7 overflow pulse", ovf_cnt - base, 1);
        for (int i = 1; i <= 2; i++) begin
            exp_clear(); exp_push(8'(i * 17));
            expect_msg("R7 queued", DEPTH);
        end
        exp_clear(); exp_push(8'd51); exp_push(8'd68);
        expect_msg("R7 merged", DEPTH);
        expect_empty("R7 after merge");
    endtask

    task automatic t_overrun();
        int base;
        base = ovr_cnt;
        exp_clear();
        for (int i = 0; i < 12; i++) begin
            send_frame(8'(8'hA0 + i), 1'b0);
            exp_push(8'(8'hA0 + i));
        end
        send_frame(8'h3C, 1'b1);
        exp_mark(8'h3C);
        chk("R3 mark at 3 free accepted", ovr_cnt - base, 0);
        send_frame(8'hEE, 1'b0);
        chk("R3 drop pulse", ovr_cnt - base, 1);
        wait_idle();
        expect_msg("R3 R9 full ring wrap", DEPTH - 1);
        chk("R3 nothing left", int'(msg_avail), 0);
    endtask

    task automatic t_overlap();
        send_frame(8'h5A, 1'b1);
        for (int i = 0; i < 7; i++) send_frame(8'(8'h31 + i), 1'b0);
        wait_idle();
        exp_clear(); exp_mark(8'h5A);
        for (int i = 0; i < 7; i++) exp_push(8'(8'h31 + i));
        fork
            send_frame(8'h6B, 1'b1);
            begin
                repeat (9 * CPB) @(negedge clk);
                expect_msg("R9 pop during receive", DEPTH);
            end
        join
        wait_idle();
        exp_clear(); exp_mark(8'h6B);
        expect_msg("R2 received during pop", DEPTH);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_short();
        t_ignore();
        t_flush();
        t_full();
        t_overrun();
        t_overlap();
        finish_run();
    end
endmodule